// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the sixteen 32-bit general registers of a processor that runs in several privilege modes. The register index the pipeline presents is translated to a physical storage slot according to the mode held in the current status word. The fast-interrupt mode swaps in private copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes each swap in a private pair for indices 13 and 14. All other indices come from one shared set.

Besides the general registers, the block keeps the current status word and one saved status word for each exception mode. Two combinational read ports and one clocked write port serve the general registers. A separate clocked port updates the current status word, either whole, only its mode field, or only its 4-bit GE field. A third port reads and writes the saved status word of the current mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register reads 0 in every mode, the status word reads 0x00000013 (supervisor), and every saved status word reads 0.
- R2: With mode field 0x10 (user) or 0x1F (system), indices 0 to 15 all address one shared set, so a value written in user mode reads back unchanged in system mode.
- R3: With mode field 0x11 (fast interrupt), indices 8 to 14 address seven private registers, and indices 0 to 7 and 15 address the shared set.
- R4: With mode field 0x12, 0x13, 0x17 or 0x1B, indices 13 and 14 address a pair of registers private to that mode, and every other index addresses the shared set.
- R5: Index 15 is never banked: a write to it in any mode is seen in every other mode.
- R6: `wr_seen` is 1 in the cycle after a cycle with `wr_en` high, and 0 in the cycle after a cycle with `wr_en` low.
- R7: Each of the five exception modes has its own saved status word on `ssw_rdata`/`ssw_we`. In user or system mode `ssw_rdata` is 0 and a saved-status write changes no stored value.
- R8: A mode field that matches none of the seven listed codes banks as user mode, and it has no saved status word.
- R9: `sw_op` = 3 loads `sw_wdata[3:0]` into status bits [19:16] and keeps all other status bits.
- R10: `sw_op` = 2 loads `sw_wdata[4:0]` into status bits [4:0] and keeps bits [31:5]. `sw_op` = 1 loads the whole word. `sw_op` = 0 leaves the status word unchanged.
- R11: A general-register or saved-status write goes to the slot chosen by the mode held before the clock edge, even if the status word changes on the same edge. Reads follow the mode currently held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| wr_seen | output | 1 | High the cycle after any register write |
| sw_op | input | 2 | Status write: 0 none, 1 whole word, 2 mode field, 3 GE field |
| sw_wdata | input | 32 | Status write data |
| sw_rdata | output | 32 | Current status word |
| ssw_we | input | 1 | Saved status write enable (current mode) |
| ssw_wdata | input | 32 | Saved status write data |
| ssw_rdata | output | 32 | Saved status word of the current mode, 0 if none |

## Verification
The bench fills the shared set in user mode and writes distinct values into every private bank. It then reads all sixteen indices through both ports in each mode. A design with a wrong boundary, such as banking index 7 or 15 in fast-interrupt mode, returns a value from the wrong mode. It also sends a register write and a mode change on the same edge. A design that used the new mode would put the value into the fast-interrupt bank instead of the user r13. The partial status writes are checked against a full word with a distinct pattern, so a mask that spills outside bits [19:16] or [4:0] changes a visible bit. Saved-status writes in user mode and an unknown mode code must leave every exception slot intact and read as zero.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DW         = 32;
    localparam int IDX_W      = 4;
    localparam int N_COMMON   = 16;
    localparam int FIQ_LO     = 8;
    localparam int FIQ_HI     = 14;
    localparam int N_FIQ      = FIQ_HI - FIQ_LO + 1;
    localparam int PAIR_LO    = 13;
    localparam int N_PAIRMODE = 4;
    localparam int FIQ_BASE   = N_COMMON;
    localparam int PAIR_BASE  = FIQ_BASE + N_FIQ;
    localparam int N_PHYS     = PAIR_BASE + 2 * N_PAIRMODE;
    localparam int PW         = $clog2(N_PHYS);
    localparam int N_EXC      = 1 + N_PAIRMODE;

    localparam logic [4:0] MC_USR = 5'h10;
    localparam logic [4:0] MC_FIQ = 5'h11;
    localparam logic [4:0] MC_IRQ = 5'h12;
    localparam logic [4:0] MC_SVC = 5'h13;
    localparam logic [4:0] MC_ABT = 5'h17;
    localparam logic [4:0] MC_UND = 5'h1B;
    localparam logic [4:0] MC_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_FULL = 2'd1,
        SW_MODE = 2'd2,
        SW_GE   = 2'd3
    } sw_op_e;

    function automatic logic [PW-1:0] phys_slot(input bank_e bank, input logic [IDX_W-1:0] idx);
        int i;
        int b;
        int slot;
        i    = int'(idx);
        b    = int'(bank);
        slot = i;
        if (bank == BK_FIQ && i >= FIQ_LO && i <= FIQ_HI) begin
            slot = FIQ_BASE + (i - FIQ_LO);
        end else if (b >= int'(BK_IRQ) && (i == PAIR_LO || i == PAIR_LO + 1)) begin
            slot = PAIR_BASE + 2 * (b - int'(BK_IRQ)) + (i - PAIR_LO);
        end
        return PW'(slot);
    endfunction

endpackage

// File: rtl/rb_mode_decode.sv
module rb_mode_decode
    import regbank_pkg::*;
(
    input  logic [4:0] mode_field,
    output bank_e      bank,
    output logic       has_saved
);
    always_comb begin
        bank      = BK_USR;
        has_saved = 1'b1;
        case (mode_field)
            MC_FIQ:  bank = BK_FIQ;
            MC_IRQ:  bank = BK_IRQ;
            MC_SVC:  bank = BK_SVC;
            MC_ABT:  bank = BK_ABT;
            MC_UND:  bank = BK_UND;
            default: begin
                bank      = BK_USR;
                has_saved = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rb_bank_map.sv
module rb_bank_map
    import regbank_pkg::*;
(
    input  bank_e            bank,
    input  logic [IDX_W-1:0] arch_idx,
    output logic [PW-1:0]    phys_idx
);
    always_comb begin
        phys_idx = phys_slot(bank, arch_idx);
    end
endmodule

// File: rtl/rb_gpr_store.sv
module rb_gpr_store
    import regbank_pkg::*;
#(
    parameter int W     = DW,
    parameter int SLOTS = N_PHYS,
    parameter int SW    = PW,
    parameter int NRD   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SW-1:0]          w_slot,
    input  logic [W-1:0]           w_data,
    input  logic [NRD-1:0][SW-1:0] r_slot,
    output logic [NRD-1:0][W-1:0]  r_data,
    output logic                   wr_seen
);
    logic [W-1:0] regs_d [SLOTS];
    logic [W-1:0] regs_q [SLOTS];
    logic         seen_d;
    logic         seen_q;

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            regs_d[s] = regs_q[s];
        end
        if (we) begin
            regs_d[w_slot] = w_data;
        end
        seen_d = we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                regs_q[s] <= '0;
            end
            seen_q <= 1'b0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                regs_q[s] <= regs_d[s];
            end
            seen_q <= seen_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign r_data[p] = regs_q[r_slot[p]];
    end

    assign wr_seen = seen_q;

    // R6
    wr_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> wr_seen);

    // R6
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !wr_seen);

    // R11
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(w_slot)] == $past(w_data));
endmodule

// File: rtl/rb_status.sv
module rb_status
    import regbank_pkg::*;
#(
    parameter int W    = DW,
    parameter int NEXC = N_EXC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op,
    input  logic [W-1:0] op_data,
    input  bank_e        bank,
    input  logic         has_saved,
    input  logic         ssw_we,
    input  logic [W-1:0] ssw_wdata,
    output logic [W-1:0] stat_word,
    output logic [W-1:0] saved_word
);
    localparam int XW = $clog2(NEXC);

    typedef struct packed {
        logic [W-1:0]            cur;
        logic [NEXC-1:0][W-1:0]  saved;
    } stat_t;

    stat_t st_d;
    stat_t st_q;
    logic [XW-1:0] exc_sel;

    always_comb begin
        exc_sel = XW'(int'(bank) - 1);
    end

    always_comb begin
        st_d = st_q;
        case (sw_op_e'(op))
            SW_FULL: st_d.cur = op_data;
            SW_MODE: st_d.cur[4:0] = op_data[4:0];
            SW_GE:   st_d.cur[19:16] = op_data[3:0];
            default: st_d.cur = st_q.cur;
        endcase
        if (ssw_we && has_saved) begin
            st_d.saved[exc_sel] = ssw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cur   <= W'(MC_SVC);
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_word  = st_q.cur;
    assign saved_word = has_saved ? st_q.saved[exc_sel] : '0;

    // R9
    ge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd3) |=> (stat_word[19:16] == $past(op_data[3:0])) &&
                         (stat_word[31:20] == $past(stat_word[31:20])) &&
                         (stat_word[15:0]  == $past(stat_word[15:0])));

    // R10
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2) |=> (stat_word[4:0] == $past(op_data[4:0])) &&
                         (stat_word[31:5] == $past(stat_word[31:5])));

    // R10
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd0) |=> $stable(stat_word));

    // R7
    saved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ssw_we && !has_saved) |=> $stable(st_q.saved));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    output logic              wr_seen,
    input  logic [1:0]        sw_op,
    input  logic [DW-1:0]     sw_wdata,
    output logic [DW-1:0]     sw_rdata,
    input  logic              ssw_we,
    input  logic [DW-1:0]     ssw_wdata,
    output logic [DW-1:0]     ssw_rdata
);
    localparam int NRD = 2;

    logic [DW-1:0]             stat_q;
    bank_e                     bank;
    logic                      has_saved;
    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0][PW-1:0]    rd_slot;
    logic [NRD-1:0][DW-1:0]    rd_data;
    logic [PW-1:0]             wr_slot;

    rb_mode_decode u_dec (
        .mode_field (stat_q[4:0]),
        .bank       (bank),
        .has_saved  (has_saved)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        rb_bank_map u_rmap (
            .bank     (bank),
            .arch_idx (rd_idx[p]),
            .phys_idx (rd_slot[p])
        );
    end

    rb_bank_map u_wmap (
        .bank     (bank),
        .arch_idx (wr_idx),
        .phys_idx (wr_slot)
    );

    rb_gpr_store #(.NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .w_slot  (wr_slot),
        .w_data  (wr_data),
        .r_slot  (rd_slot),
        .r_data  (rd_data),
        .wr_seen (wr_seen)
    );

    rb_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (sw_op),
        .op_data    (sw_wdata),
        .bank       (bank),
        .has_saved  (has_saved),
        .ssw_we     (ssw_we),
        .ssw_wdata  (ssw_wdata),
        .stat_word  (stat_q),
        .saved_word (ssw_rdata)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign sw_rdata  = stat_q;

    // R5
    pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15 && sw_op == 2'd2 && rd_a_idx == 4'd15) |=>
        (rd_a_idx != 4'd15) || (rd_a_data == $past(wr_data)));
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_seen;
    logic [1:0]  sw_op = 2'd0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        ssw_we = 1'b0;
    logic [31:0] ssw_wdata = '0;
    logic [31:0] ssw_rdata;

    banked_regfile dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = sw_rdata;
                3: act = ssw_rdata;
                default: act = {31'b0, wr_seen};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        wr_en  = 1'b0;
        sw_op  = 2'd0;
        ssw_we = 1'b0;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        step();
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
    endtask

    task automatic setm(input logic [4:0] m);
        step();
        sw_op = 2'd2; sw_wdata = {27'h5AB_CDEF, m};
    endtask

    task automatic rd2(input logic [3:0] ia, input logic [31:0] ea,
                       input logic [3:0] ib, input logic [31:0] eb, input string tag);
        step();
        rd_a_idx = ia; rd_b_idx = ib;
        push(0, ea, tag);
        push(1, eb, tag);
    endtask

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        step();
        push(kind, exp, tag);
    endtask

    function automatic logic [31:0] user_val(input int i);
        return 32'h1000 + i;
    endfunction

    logic [4:0] pair_modes [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state in supervisor mode
        chk(2, 32'h0000_0013, "R1 status reset");
        chk(3, 32'h0, "R1 saved reset");
        for (int i = 0; i < 16; i += 2) rd2(4'(i), 0, 4'(i + 1), 0, "R1 regs reset");
        setm(5'h11);
        for (int i = 8; i < 16; i += 2) rd2(4'(i), 0, 4'(i + 1), 0, "R1 fiq regs reset");
        chk(3, 32'h0, "R1 fiq saved reset");

        // R2 fill shared set in user mode
        setm(5'h10);
        for (int i = 0; i < 16; i++) wr(4'(i), user_val(i));
        chk(4, 32'h1, "R6 seen after write");
        chk(4, 32'h0, "R6 quiet after idle");
        for (int i = 0; i < 16; i += 2) rd2(4'(i), user_val(i), 4'(i + 1), user_val(i + 1), "R2 user");
        setm(5'h1F);
        for (int i = 0; i < 16; i += 2) rd2(4'(i), user_val(i), 4'(i + 1), user_val(i + 1), "R2 system");

        // R3 fast-interrupt bank
        setm(5'h11);
        for (int i = 8; i <= 14; i++) wr(4'(i), 32'hF000 + i);
        for (int i = 0; i < 8; i++) rd2(4'(i), user_val(i), 4'(i + 8), (i + 8 == 15) ? user_val(15) : 32'hF000 + i + 8, "R3 fiq");
        setm(5'h10);
        for (int i = 8; i < 16; i += 2) rd2(4'(i), user_val(i), 4'(i + 1), user_val(i + 1), "R3 user untouched");

        // R4 pair-banked modes
        for (int k = 0; k < 4; k++) begin
            setm(pair_modes[k]);
            wr(4'd13, 32'h2000 + 16 * k);
            wr(4'd14, 32'h2001 + 16 * k);
        end
        for (int k = 0; k < 4; k++) begin
            setm(pair_modes[k]);
            rd2(4'd13, 32'h2000 + 16 * k, 4'd14, 32'h2001 + 16 * k, "R4 pair");
            rd2(4'd12, user_val(12), 4'd8, user_val(8), "R4 shared");
        end
        setm(5'h10);
        rd2(4'd13, user_val(13), 4'd14, user_val(14), "R4 user untouched");

        // R5 index 15 shared
        setm(5'h1B);
        wr(4'd15, 32'h0000_DEAD);
        setm(5'h11);
        rd2(4'd15, 32'h0000_DEAD, 4'd14, 32'hF00E, "R5 fiq pc");
        setm(5'h10);
        rd2(4'd15, 32'h0000_DEAD, 4'd15, 32'h0000_DEAD, "R5 user pc");

        // R7 saved status words
        for (int k = 0; k < 5; k++) begin
            setm(k == 0 ? 5'h11 : pair_modes[k - 1]);
            step(); ssw_we = 1'b1; ssw_wdata = 32'h5000 + k;
        end
        setm(5'h10);
        step(); ssw_we = 1'b1; ssw_wdata = 32'hBAD0;
        chk(3, 32'h0, "R7 user saved zero");
        setm(5'h1F);
        chk(3, 32'h0, "R7 system saved zero");
        for (int k = 0; k < 5; k++) begin
            setm(k == 0 ? 5'h11 : pair_modes[k - 1]);
            chk(3, 32'h5000 + k, "R7 saved per mode");
        end

        // R8 unknown mode code banks as user
        setm(5'h05);
        rd2(4'd13, user_val(13), 4'd9, user_val(9), "R8 unknown mode");
        chk(3, 32'h0, "R8 unknown no saved");

        // R9 / R10 status field writes
        step(); sw_op = 2'd1; sw_wdata = 32'hA5A5_A5B2;
        chk(2, 32'hA5A5_A5B2, "R10 full write");
        step(); sw_op = 2'd3; sw_wdata = 32'hFFFF_FFF3;
        chk(2, 32'hA5A3_A5B2, "R9 ge write");
        step(); sw_op = 2'd2; sw_wdata = 32'h0000_001B;
        chk(2, 32'hA5A3_A5BB, "R10 mode write");
        step(); sw_op = 2'd0; sw_wdata = 32'hFFFF_FFFF;
        chk(2, 32'hA5A3_A5BB, "R10 no op");

        // R11 write and mode change on one edge
        setm(5'h10);
        step();
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h77;
        sw_op = 2'd2; sw_wdata = 32'h11;
        rd2(4'd13, 32'hF00D, 4'd8, 32'hF008, "R11 fiq untouched");
        setm(5'h10);
        rd2(4'd13, 32'h77, 4'd12, user_val(12), "R11 old mode took write");

        step();
        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule